// File: doc/BRIEF.md
# GPIO Port Pin-Ownership Multiplexer

This block controls one port of general-purpose pads and decides, pad by pad, whether a pad belongs to an on-chip peripheral or to software-driven general-purpose I/O. Each pad has its own ownership bit. When the bit is clear, the GPIO logic owns the pad. When it is set, a peripheral owns the pad, and a select field shared by a group of adjacent pads picks which of the competing peripherals that is. A small word-wide register bus programs ownership, peripheral selection, GPIO direction, GPIO input-buffer enable and GPIO output data. The same bus reads a synchronised, input-enable-gated view of the pads.

For every pad the block produces an output value and an output enable. It steers the pad input to exactly one selected peripheral input, or to none. Separately, it hands every pad value straight to side-channel inputs that ignore ownership altogether. These are used by modules that only observe a pin, such as a position counter.

Top module: `gpio_pinmux_port`

## Requirements
- R1: After reset, all five control registers read 0. Every pad is therefore GPIO-owned with its output enable low, and the input data view reads 0.
- R2: A write on `bus_wr` stores the whole 16-bit word at the following clock edge. Ownership is at offset 0x0, peripheral select at 0x2, direction at 0x4, input enable at 0x6 and output data at 0x8. A read at that offset returns the stored word on `bus_rdata` combinationally from `bus_addr`.
- R3: The input data view at offset 0xA is read-only: writing it changes no register. Any other address, including odd addresses, reads 0.
- R4: A pad whose ownership bit is 0 drives `pad_out` from its output-data bit and `pad_oe` from its direction bit.
- R5: A pad whose ownership bit is 1 takes `pad_out` and `pad_oe` from peripheral p. Pad i belongs to group i/2, whose 2-bit select field sits at bits [2g+1:2g] of the select register and holds p. Peripheral p drives pad i on bit p*16+i of `periph_out` and `periph_oe`.
- R6: Bit p*16+i of `periph_in` equals `pad_in[i]` when pad i is peripheral-owned and its group selects p; otherwise it is 0. At most one peripheral receives any pad.
- R7: A select field applies to both pads of its group, yet each pad of the group still follows its own ownership bit. A GPIO pad sharing a group with a peripheral-owned pad behaves exactly as in R4.
- R8: Bit i of the input data view is 0 while input-enable bit i is 0. Otherwise it equals `pad_in[i]` as sampled two clock edges earlier.
- R9: `aux_in` always equals `pad_in`, whatever the ownership and select settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register byte offset |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr` |
| pad_in | input | 16 | Pad input values |
| pad_out | output | 16 | Pad output values |
| pad_oe | output | 16 | Pad output enables |
| periph_out | input | 64 | Peripheral output values, peripheral-major |
| periph_oe | input | 64 | Peripheral output enables, peripheral-major |
| periph_in | output | 64 | Pad values steered to peripherals, peripheral-major |
| aux_in | output | 16 | Unconditional pad observation inputs |

## Verification
Two things can land in the same cycle. A register write can change a pad's owner or group select while the pad inputs and peripheral drives are also changing. A read of the input view can coincide with a write to input enable or with the pad moving. The bench forces both by issuing random writes, including writes to the read-only and unmapped offsets, on the same cycles that it randomises the pads, the peripheral drives and the read address. A behavioural model keeps register copies and a two-deep history queue of pad values. Every pad, peripheral and read output is compared against that model on every clock, so a write must become visible exactly one edge later and the input view must lag the pad by exactly two edges.

// File: rtl/pinmux_pkg.sv
package pinmux_pkg;
    typedef enum logic [3:0] {
        REG_OWNER  = 4'h0,
        REG_SELECT = 4'h2,
        REG_DIR    = 4'h4,
        REG_INEN   = 4'h6,
        REG_DOUT   = 4'h8,
        REG_DIN    = 4'hA
    } reg_off_e;
endpackage

// File: rtl/pinmux_regs.sv
module pinmux_regs #(
    parameter int W     = 16,
    parameter int SEL_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [3:0]       addr,
    input  logic [W-1:0]     wdata,
    output logic [W-1:0]     own_q,
    output logic [SEL_W-1:0] sel_q,
    output logic [W-1:0]     dir_q,
    output logic [W-1:0]     inen_q,
    output logic [W-1:0]     dout_q
);
    import pinmux_pkg::*;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            own_q  <= '0;
            sel_q  <= '0;
            dir_q  <= '0;
            inen_q <= '0;
            dout_q <= '0;
        end else if (wr_en) begin
            case (addr)
                REG_OWNER:  own_q  <= wdata;
                REG_SELECT: sel_q  <= wdata[SEL_W-1:0];
                REG_DIR:    dir_q  <= wdata;
                REG_INEN:   inen_q <= wdata;
                REG_DOUT:   dout_q <= wdata;
                default: ;
            endcase
        end
    end

    // R2: a write lands on the next edge
    assert_dir_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == REG_DIR) |=> dir_q == $past(wdata));
    assert_owner_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == REG_OWNER) |=> own_q == $past(wdata));

    // R3: the input view offset holds no storage
    assert_din_readonly_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == REG_DIN) |=> ($stable(own_q) && $stable(sel_q) &&
            $stable(dir_q) && $stable(inen_q) && $stable(dout_q)));
endmodule

// File: rtl/pinmux_sync.sv
module pinmux_sync #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1_q <= '0;
            q        <= '0;
        end else begin
            stage1_q <= d;
            q        <= stage1_q;
        end
    end
endmodule

// File: rtl/pinmux_route.sv
module pinmux_route #(
    parameter int NUM_PINS = 16,
    parameter int GRP_PINS = 2,
    parameter int SEL_W    = 2,
    localparam int NUM_PERIPH = 1 << SEL_W,
    localparam int NUM_GROUPS = NUM_PINS / GRP_PINS,
    localparam int SELREG_W   = NUM_GROUPS * SEL_W,
    localparam int FLAT_W     = NUM_PERIPH * NUM_PINS
) (
    input  logic [NUM_PINS-1:0] own,
    input  logic [SELREG_W-1:0] sel,
    input  logic [NUM_PINS-1:0] dout,
    input  logic [NUM_PINS-1:0] dir,
    input  logic [NUM_PINS-1:0] pad_in,
    input  logic [FLAT_W-1:0]   pout,
    input  logic [FLAT_W-1:0]   poe,
    output logic [NUM_PINS-1:0] pad_out,
    output logic [NUM_PINS-1:0] pad_oe,
    output logic [FLAT_W-1:0]   pin
);
    for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
        localparam int GRP = i / GRP_PINS;
        logic [SEL_W-1:0]      pick;
        logic [NUM_PERIPH-1:0] cand_o;
        logic [NUM_PERIPH-1:0] cand_e;

        assign pick = sel[GRP*SEL_W +: SEL_W];

        for (genvar p = 0; p < NUM_PERIPH; p++) begin : g_src
            assign cand_o[p] = pout[p*NUM_PINS + i];
            assign cand_e[p] = poe[p*NUM_PINS + i];
            assign pin[p*NUM_PINS + i] = own[i] && (pick == SEL_W'(p)) && pad_in[i];
        end

        assign pad_out[i] = own[i] ? cand_o[pick] : dout[i];
        assign pad_oe[i]  = own[i] ? cand_e[pick] : dir[i];
    end
endmodule

// File: rtl/gpio_pinmux_port.sv
module gpio_pinmux_port #(
    parameter int NUM_PINS = 16,
    parameter int GRP_PINS = 2,
    parameter int SEL_W    = 2,
    localparam int NUM_PERIPH = 1 << SEL_W,
    localparam int NUM_GROUPS = NUM_PINS / GRP_PINS,
    localparam int SELREG_W   = NUM_GROUPS * SEL_W,
    localparam int FLAT_W     = NUM_PERIPH * NUM_PINS
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_wr,
    input  logic [3:0]          bus_addr,
    input  logic [NUM_PINS-1:0] bus_wdata,
    output logic [NUM_PINS-1:0] bus_rdata,
    input  logic [NUM_PINS-1:0] pad_in,
    output logic [NUM_PINS-1:0] pad_out,
    output logic [NUM_PINS-1:0] pad_oe,
    input  logic [FLAT_W-1:0]   periph_out,
    input  logic [FLAT_W-1:0]   periph_oe,
    output logic [FLAT_W-1:0]   periph_in,
    output logic [NUM_PINS-1:0] aux_in
);
    import pinmux_pkg::*;

    logic [NUM_PINS-1:0] own_q, dir_q, inen_q, dout_q, din_sync;
    logic [SELREG_W-1:0] sel_q;

    pinmux_regs #(.W(NUM_PINS), .SEL_W(SELREG_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
        .own_q(own_q), .sel_q(sel_q), .dir_q(dir_q), .inen_q(inen_q), .dout_q(dout_q)
    );

    pinmux_sync #(.W(NUM_PINS)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(pad_in), .q(din_sync)
    );

    pinmux_route #(.NUM_PINS(NUM_PINS), .GRP_PINS(GRP_PINS), .SEL_W(SEL_W)) u_route (
        .own(own_q), .sel(sel_q), .dout(dout_q), .dir(dir_q), .pad_in(pad_in),
        .pout(periph_out), .poe(periph_oe),
        .pad_out(pad_out), .pad_oe(pad_oe), .pin(periph_in)
    );

    assign aux_in = pad_in;

    always_comb begin
        case (bus_addr)
            REG_OWNER:  bus_rdata = own_q;
            REG_SELECT: bus_rdata = NUM_PINS'(sel_q);
            REG_DIR:    bus_rdata = dir_q;
            REG_INEN:   bus_rdata = inen_q;
            REG_DOUT:   bus_rdata = dout_q;
            REG_DIN:    bus_rdata = din_sync & inen_q;
            default:    bus_rdata = '0;
        endcase
    end

    // R1: first cycle out of reset has every driver off
    assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (pad_oe == '0));

    // R8: disabled input buffers never show a 1 on the input view
    assert_din_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == REG_DIN) |-> ((bus_rdata & ~inen_q) == '0));

    // R6: steering only to owned pads, at most one receiver per pad
    for (genvar i = 0; i < NUM_PINS; i++) begin : g_chk
        logic [NUM_PERIPH-1:0] rx;
        for (genvar p = 0; p < NUM_PERIPH; p++) begin : g_rx
            assign rx[p] = periph_in[p*NUM_PINS + i];
        end
        assert_single_rx_R6: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(rx));
        assert_owned_rx_R6: assert property (@(posedge clk) disable iff (!rst_n)
            !own_q[i] |-> (rx == '0));
    end
endmodule

// File: tb/gpio_pinmux_port_bench.sv
module gpio_pinmux_port_bench;
    localparam int N = 16;
    localparam int F = 64;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         bus_wr = 1'b0;
    logic [3:0]   bus_addr = 4'h0;
    logic [N-1:0] bus_wdata = '0;
    logic [N-1:0] bus_rdata;
    logic [N-1:0] pad_in = '0;
    logic [N-1:0] pad_out, pad_oe, aux_in;
    logic [F-1:0] periph_out = '0;
    logic [F-1:0] periph_oe = '0;
    logic [F-1:0] periph_in;

    int n_tests = 0;
    int n_fail  = 0;
    bit cmp_on  = 1'b0;

    always #4 clk = ~clk;

    gpio_pinmux_port u_gpio_pinmux_port (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .periph_out(periph_out),
        .periph_oe(periph_oe), .periph_in(periph_in), .aux_in(aux_in)
    );

    // behavioural reference
    logic [N-1:0] m_own, m_sel, m_dir, m_inen, m_dout;
    logic [N-1:0] hist[$];

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_own = '0; m_sel = '0; m_dir = '0; m_inen = '0; m_dout = '0;
            hist.delete();
        end else begin
            if (bus_wr) begin
                case (bus_addr)
                    4'h0: m_own  = bus_wdata;
                    4'h2: m_sel  = bus_wdata;
                    4'h4: m_dir  = bus_wdata;
                    4'h6: m_inen = bus_wdata;
                    4'h8: m_dout = bus_wdata;
                    default: ;
                endcase
            end
            hist.push_back(pad_in);
            if (hist.size() > 2) void'(hist.pop_front());
        end
    end

    task automatic chk(string req, string what, logic [F-1:0] act, logic [F-1:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h at %0t", req, what, act, exp, $time);
        end
    endtask

    function automatic logic [N-1:0] exp_rdata();
        logic [N-1:0] d;
        d = (hist.size() == 2) ? hist[0] : '0;
        case (bus_addr)
            4'h0: return m_own;
            4'h2: return m_sel;
            4'h4: return m_dir;
            4'h6: return m_inen;
            4'h8: return m_dout;
            4'hA: return d & m_inen;
            default: return '0;
        endcase
    endfunction

    always @(negedge clk) begin
        if (cmp_on && rst_n) begin
            logic [N-1:0] e_out, e_oe;
            logic [F-1:0] e_pin;
            e_pin = '0;
            for (int i = 0; i < N; i++) begin
                int s;
                s = int'(m_sel[2*(i/2) +: 2]);
                e_out[i] = m_own[i] ? periph_out[s*N + i] : m_dout[i];
                e_oe[i]  = m_own[i] ? periph_oe[s*N + i]  : m_dir[i];
                if (m_own[i]) e_pin[s*N + i] = pad_in[i];
            end
            chk("R4/R5", "pad_out", F'(pad_out), F'(e_out));
            chk("R4/R5", "pad_oe", F'(pad_oe), F'(e_oe));
            chk("R6", "periph_in", periph_in, e_pin);
            chk("R9", "aux_in", F'(aux_in), F'(pad_in));
            if (bus_addr == 4'hA)
                chk("R8", "din", F'(bus_rdata), F'(exp_rdata()));
            else if (bus_addr inside {4'h0, 4'h2, 4'h4, 4'h6, 4'h8})
                chk("R2", "rdata", F'(bus_rdata), F'(exp_rdata()));
            else
                chk("R3", "unmapped", F'(bus_rdata), F'(exp_rdata()));
        end
    end

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic wr(logic [3:0] a, logic [N-1:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        step();
        bus_wr = 1'b0;
    endtask

    task automatic rd_chk(logic [3:0] a, logic [N-1:0] e, string req);
        bus_addr = a;
        @(negedge clk);
        chk(req, "directed read", F'(bus_rdata), F'(e));
        step();
    endtask

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        #(8 * 150000);
        n_tests++; n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        // R1: reset state
        pad_in = 16'hFFFF;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "oe after reset", F'(pad_oe), '0);
        chk("R1", "out after reset", F'(pad_out), '0);
        step();
        for (int a = 0; a <= 10; a += 2) rd_chk(4'(a), '0, "R1");
        cmp_on = 1'b1;

        // R2: whole-word writes
        wr(4'h4, 16'hA5C3);
        rd_chk(4'h4, 16'hA5C3, "R2");
        wr(4'h8, 16'h0F0F);
        rd_chk(4'h8, 16'h0F0F, "R2");

        // R3: write to input view leaves every register
        wr(4'hA, 16'hFFFF);
        rd_chk(4'h4, 16'hA5C3, "R3");
        rd_chk(4'h0, 16'h0000, "R3");
        rd_chk(4'h7, 16'h0000, "R3");

        // R7: pad0 peripheral (group0 -> source 2), pad1 GPIO output
        wr(4'h0, 16'h0001);
        wr(4'h2, 16'h0002);
        wr(4'h4, 16'h0002);
        wr(4'h8, 16'h0002);
        periph_out = '0; periph_oe = '0;
        periph_out[2*N + 0] = 1'b1; periph_oe[2*N + 0] = 1'b1;
        periph_out[2*N + 1] = 1'b0; periph_oe[2*N + 1] = 1'b0;
        @(negedge clk);
        chk("R7", "gpio pad1 out", F'(pad_out[1]), F'(1'b1));
        chk("R7", "gpio pad1 oe", F'(pad_oe[1]), F'(1'b1));
        chk("R5", "periph pad0 oe", F'(pad_oe[0]), F'(1'b1));
        step();

        // R8: input view lags two edges, gated by input enable
        wr(4'h6, 16'h00FF);
        pad_in = 16'h1234;
        bus_addr = 4'hA;
        step(); step();
        @(negedge clk);
        chk("R8", "din gated", F'(bus_rdata), F'(16'h0034));
        step();

        // random concurrency phase
        for (int c = 0; c < 4000; c++) begin
            pad_in     = 16'($urandom);
            periph_out = {$urandom, $urandom};
            periph_oe  = {$urandom, $urandom};
            bus_addr   = 4'($urandom_range(0, 15));
            bus_wr     = ($urandom_range(0, 3) == 0);
            bus_wdata  = 16'($urandom);
            if (c == 2000) begin
                rst_n = 1'b0;
                step();
                @(negedge clk);
                chk("R1", "oe during reset", F'(pad_oe), '0);
                #1 rst_n = 1'b1;
            end
            step();
        end
        bus_wr = 1'b0;
        step();
        finish_run();
    end
endmodule